// File: doc/BRIEF.md
# I2C master bit-level bus engine

This block sits between a byte-level I2C sequencer and the two open-drain bus wires. It carries out one bus primitive per command: a START condition, a repeated START, a STOP condition, one data bit written, or one data bit read. Each primitive is a fixed series of wire moves and checks, with every interval timed by a half-bit delay whose length in system clock cycles is set at run time.

The engine drives the wires only as pull-low enables (1 pulls the wire low, 0 leaves it to the pull-up) and reads both wires back through a two-flop synchronizer. Whenever it lets the clock wire go high it waits until the wire really reads high, so a slave may stretch the clock. While waiting it polls once per delay period and gives up with a timeout error if the sequencer's timeout-expired input is high at a poll. Where the engine expects data high but reads it low, it reports lost arbitration. Every command ends with a single-cycle done pulse carrying the read bit and the error flags.

Top module: `i2cb_engine`

## Requirements
- R1: After reset both pull-low enables are 0 (wires released), cmd_ready is 1, and done, err_arb and err_tmo are 0.
- R2: A command is taken in a cycle where cmd_valid and cmd_ready are both 1; cmd_ready stays 0 from the next cycle until the done pulse, and each taken command yields exactly one single-cycle done pulse. Op codes: 0 START, 1 repeated START, 2 STOP, 3 write bit, 4 read bit.
- R3: START waits one delay, then samples data; if data reads low it ends with err_arb and no wire move, otherwise it pulls data low, waits one delay and pulls clock low.
- R4: Repeated START releases data, waits one delay, releases clock, waits for clock high, waits one delay, samples data (low gives err_arb), then pulls data low, waits one delay and pulls clock low.
- R5: STOP pulls data low, waits one delay, releases clock, waits for clock high, waits one delay, releases data, waits one delay and samples data; low there gives err_arb. Success leaves both wires released.
- R6: Write bit (issued with clock held low) sets data to cmd_wbit, waits one delay, releases clock, waits one delay, waits for clock high, checks arbitration when the bit is 1, then pulls clock low. Data moves while clock is released only in START, repeated START, STOP, or on error cleanup.
- R7: Read bit (issued with clock held low) releases data, waits one delay, releases clock, waits for clock high, waits one delay, samples data into rd_bit (valid from the done pulse on), then pulls clock low.
- R8: After a clock release the engine proceeds only once the synchronized clock reads high; while it reads low the engine rechecks once per delay period, indefinitely while the timeout input stays 0.
- R9: If tmo_expired is 1 at a poll where the clock still reads low, the command ends with err_tmo.
- R10: If a written 1 reads back low on data, the command ends with err_arb.
- R11: Consecutive wire moves within one command are at least half_cycles clock cycles apart; a half_cycles of 0 acts as 1.
- R12: An error ends the command at once: done pulses together with exactly one of err_arb or err_tmo; both wires are then released, except after STOP, where the wires keep their state.
- R13: Op codes 5 to 7 end with a done pulse, no error and no wire move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Command code (see R2, R13) |
| cmd_wbit | input | 1 | Bit value for a write command |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| half_cycles | input | DLY_W | Half-bit delay length in clock cycles (0 acts as 1) |
| tmo_expired | input | 1 | Timeout expired indication from the sequencer |
| scl_in | input | 1 | Clock wire level as read from the bus |
| sda_in | input | 1 | Data wire level as read from the bus |
| scl_drive_low | output | 1 | 1 pulls the clock wire low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls the data wire low, 0 releases it |
| done | output | 1 | Single-cycle command completion pulse |
| rd_bit | output | 1 | Last sampled read bit |
| err_arb | output | 1 | Arbitration lost, valid with done |
| err_tmo | output | 1 | Clock stretch timeout, valid with done |

## Verification
The assertions watch, on every cycle, the handshake and single done pulse, the minimum spacing between wire moves, that data only moves under a released clock for bus conditions or cleanup, that error flags are exclusive and coincide with done, that a timeout follows a high timeout input, and the wire state left by each successful or failed command. The exact order of wire moves for each primitive, the value captured by a read, the wait through a stretched clock, arbitration loss at START and on a written 1, the STOP timeout leaving the wires held, and the no-op codes can only be shown by the bench scenarios, which compare the recorded wire moves against expected sequences built from the requirements.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  localparam int STEP_W = 4;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RESTART = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    U_END,
    U_WAIT,
    U_WAITHI,
    U_ARB,
    U_ARBW,
    U_SDA_LO,
    U_SDA_REL,
    U_SDA_BIT,
    U_SCL_LO,
    U_SCL_REL,
    U_SAMPLE
  } uop_e;

  // Micro-step table: which action a command performs at a given step.
  function automatic uop_e uop_at(input logic [2:0] op, input logic [STEP_W-1:0] step);
    uop_e u;
    u = U_END;
    case (op)
      OP_START: case (step)
        4'd0: u = U_WAIT;
        4'd1: u = U_ARB;
        4'd2: u = U_SDA_LO;
        4'd3: u = U_WAIT;
        4'd4: u = U_SCL_LO;
        default: u = U_END;
      endcase
      OP_RESTART: case (step)
        4'd0: u = U_SDA_REL;
        4'd1: u = U_WAIT;
        4'd2: u = U_SCL_REL;
        4'd3: u = U_WAITHI;
        4'd4: u = U_WAIT;
        4'd5: u = U_ARB;
        4'd6: u = U_SDA_LO;
        4'd7: u = U_WAIT;
        4'd8: u = U_SCL_LO;
        default: u = U_END;
      endcase
      OP_STOP: case (step)
        4'd0: u = U_SDA_LO;
        4'd1: u = U_WAIT;
        4'd2: u = U_SCL_REL;
        4'd3: u = U_WAITHI;
        4'd4: u = U_WAIT;
        4'd5: u = U_SDA_REL;
        4'd6: u = U_WAIT;
        4'd7: u = U_ARB;
        default: u = U_END;
      endcase
      OP_WRITE: case (step)
        4'd0: u = U_SDA_BIT;
        4'd1: u = U_WAIT;
        4'd2: u = U_SCL_REL;
        4'd3: u = U_WAIT;
        4'd4: u = U_WAITHI;
        4'd5: u = U_ARBW;
        4'd6: u = U_SCL_LO;
        default: u = U_END;
      endcase
      OP_READ: case (step)
        4'd0: u = U_SDA_REL;
        4'd1: u = U_WAIT;
        4'd2: u = U_SCL_REL;
        4'd3: u = U_WAITHI;
        4'd4: u = U_WAIT;
        4'd5: u = U_SAMPLE;
        4'd6: u = U_SCL_LO;
        default: u = U_END;
      endcase
      default: u = U_END;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '1;
        else if (s == 0) pipe[s] <= din;
        else pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/i2cb_delay.sv
module i2cb_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DLY_W-1:0] len,
  output logic             busy,
  output logic             fin
);

  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= (len == '0) ? '0 : len - 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end

  assign fin = busy && (cnt == '0);

endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_wbit,
  output logic             cmd_ready,
  input  logic [DLY_W-1:0] half_cycles,
  input  logic             tmo_expired,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_drive_low,
  output logic             sda_drive_low,
  output logic             done,
  output logic             rd_bit,
  output logic             err_arb,
  output logic             err_tmo
);

  logic              busy;
  logic [2:0]        op_q;
  logic              wbit_q;
  logic [STEP_W-1:0] step;
  logic [1:0]        bus_s;
  logic              scl_s, sda_s;
  logic              dly_start, dly_busy, dly_fin;
  logic              fail_arb, fail_tmo;
  uop_e              uop;

  i2cb_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din({scl_in, sda_in}), .dout(bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  assign uop = uop_at(op_q, step);

  always_comb begin
    dly_start = 1'b0;
    fail_arb  = 1'b0;
    fail_tmo  = 1'b0;
    if (busy) begin
      case (uop)
        U_WAIT:   dly_start = !dly_busy;
        U_WAITHI: begin
          dly_start = !dly_busy && !scl_s && !tmo_expired;
          fail_tmo  = !dly_busy && !scl_s && tmo_expired;
        end
        U_ARB:    fail_arb = !sda_s;
        U_ARBW:   fail_arb = wbit_q && !sda_s;
        default: ;
      endcase
    end
  end

  i2cb_delay #(.DLY_W(DLY_W)) u_delay (
    .clk(clk), .rst(rst), .start(dly_start), .len(half_cycles),
    .busy(dly_busy), .fin(dly_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy          <= 1'b0;
      op_q          <= 3'd0;
      wbit_q        <= 1'b0;
      step          <= '0;
      scl_drive_low <= 1'b0;
      sda_drive_low <= 1'b0;
      done          <= 1'b0;
      rd_bit        <= 1'b0;
      err_arb       <= 1'b0;
      err_tmo       <= 1'b0;
    end else begin
      done    <= 1'b0;
      err_arb <= 1'b0;
      err_tmo <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy   <= 1'b1;
          op_q   <= cmd_op;
          wbit_q <= cmd_wbit;
          step   <= '0;
        end
      end else if (fail_arb || fail_tmo) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        err_arb <= fail_arb;
        err_tmo <= fail_tmo;
        if (op_q != OP_STOP) begin
          scl_drive_low <= 1'b0;
          sda_drive_low <= 1'b0;
        end
      end else begin
        case (uop)
          U_END: begin
            busy <= 1'b0;
            done <= 1'b1;
          end
          U_WAIT:    if (dly_fin) step <= step + 1'b1;
          U_WAITHI:  if (!dly_busy && scl_s) step <= step + 1'b1;
          U_SDA_LO:  begin sda_drive_low <= 1'b1;    step <= step + 1'b1; end
          U_SDA_REL: begin sda_drive_low <= 1'b0;    step <= step + 1'b1; end
          U_SDA_BIT: begin sda_drive_low <= !wbit_q; step <= step + 1'b1; end
          U_SCL_LO:  begin scl_drive_low <= 1'b1;    step <= step + 1'b1; end
          U_SCL_REL: begin scl_drive_low <= 1'b0;    step <= step + 1'b1; end
          U_SAMPLE:  begin rd_bit <= sda_s;          step <= step + 1'b1; end
          default:   step <= step + 1'b1;
        endcase
      end
    end
  end

  assign cmd_ready = !busy;

endmodule

// File: rtl/i2cb_engine_chk.sv
module i2cb_engine_chk
  import i2cb_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [DLY_W-1:0] half_cycles,
  input logic             tmo_expired,
  input logic             scl_drive_low,
  input logic             sda_drive_low,
  input logic             done,
  input logic             err_arb,
  input logic             err_tmo,
  input logic [2:0]       op_q
);

  logic [1:0]  prev_pair;
  logic        chg, seen;
  int unsigned gap;
  int unsigned hmin;
  logic        bus_op;

  assign chg    = {scl_drive_low, sda_drive_low} != prev_pair;
  assign hmin   = (half_cycles == '0) ? 1 : int'(half_cycles);
  assign bus_op = (op_q == OP_START) || (op_q == OP_RESTART) || (op_q == OP_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_pair <= 2'b00;
      gap       <= 0;
      seen      <= 1'b0;
    end else begin
      prev_pair <= {scl_drive_low, sda_drive_low};
      if (cmd_valid && cmd_ready) begin
        gap  <= 0;
        seen <= 1'b0;
      end else if (chg) begin
        gap  <= 0;
        seen <= 1'b1;
      end else if (gap < 32'hFFFF_0000) begin
        gap <= gap + 1;
      end
    end
  end

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R2
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!cmd_ready));

  // R6
  sda_move_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_drive_low) && $past(!scl_drive_low)) |-> (done || bus_op));

  // R11
  gap_chk: assert property (@(posedge clk) disable iff (rst)
    (chg && seen && !done) |-> (gap + 1 >= hmin));

  // R12
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (err_arb || err_tmo) |-> (done && !(err_arb && err_tmo)));

  // R12
  err_release_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (err_arb || err_tmo) && op_q != OP_STOP) |-> (!scl_drive_low && !sda_drive_low));

  // R9
  tmo_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err_tmo |-> $past(tmo_expired));

  // R5
  stop_end_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_STOP && !err_arb && !err_tmo) |-> (!scl_drive_low && !sda_drive_low));

  // R7
  read_end_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_READ && !err_arb && !err_tmo) |-> scl_drive_low);

endmodule

bind i2cb_engine i2cb_engine_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .half_cycles(half_cycles), .tmo_expired(tmo_expired),
  .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
  .done(done), .err_arb(err_arb), .err_tmo(err_tmo), .op_q(op_q)
);

// File: tb/i2cb_engine_bench.sv
module i2cb_engine_bench;
  import i2cb_pkg::*;

  localparam int DLY_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_valid = 1'b0;
  logic [2:0]       cmd_op = 3'd0;
  logic             cmd_wbit = 1'b0;
  logic             cmd_ready;
  logic [DLY_W-1:0] half_cycles = 16'd4;
  logic             tmo_expired = 1'b0;
  logic             scl_in, sda_in;
  logic             scl_drive_low, sda_drive_low;
  logic             done, rd_bit, err_arb, err_tmo;

  logic stretch = 1'b0;
  logic slave_sda = 1'b0;

  assign scl_in = !(scl_drive_low || stretch);
  assign sda_in = !(sda_drive_low || slave_sda);

  always #10 clk = ~clk;

  i2cb_engine #(.DLY_W(DLY_W)) u_i2cb_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .cmd_ready(cmd_ready), .half_cycles(half_cycles),
    .tmo_expired(tmo_expired), .scl_in(scl_in), .sda_in(sda_in),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .done(done), .rd_bit(rd_bit), .err_arb(err_arb), .err_tmo(err_tmo)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_chg = 0;
  int starts = 0;
  int stops = 0;
  bit mon_seen = 0;
  logic [1:0] mon_prev = 2'b00;
  logic prev_scl_line = 1'b1, prev_sda_line = 1'b1;
  logic [1:0] act_q[$];
  logic [1:0] exp_q[$];
  logic [1:0] exp_last;
  logic got_rd, got_arb, got_tmo, got_done;
  int done_cyc, rel_cyc;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Line monitor: records every move of the pull-low pair and checks spacing.
  always @(negedge clk) begin
    logic [1:0] cur;
    int hm;
    cyc++;
    if (!rst) begin
      cur = {scl_drive_low, sda_drive_low};
      hm = (half_cycles == 0) ? 1 : int'(half_cycles);
      if (cur != mon_prev) begin
        act_q.push_back(cur);
        if (mon_seen && !done)
          chk((cyc - last_chg) >= hm, "R11 move spacing", cyc - last_chg, hm);
        mon_seen = 1;
        last_chg = cyc;
      end
      mon_prev = cur;
      if (prev_scl_line && scl_in) begin
        if (prev_sda_line && !sda_in) starts++;
        if (!prev_sda_line && sda_in) stops++;
      end
      prev_scl_line = scl_in;
      prev_sda_line = sda_in;
    end
  end

  task automatic begin_cmd();
    act_q.delete();
    exp_q.delete();
    exp_last = {scl_drive_low, sda_drive_low};
  endtask

  task automatic exp_set(input bit scl_lo, input bit sda_lo);
    if ({scl_lo, sda_lo} != exp_last) begin
      exp_q.push_back({scl_lo, sda_lo});
      exp_last = {scl_lo, sda_lo};
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input bit wb, input string tag);
    int n;
    @(negedge clk);
    mon_seen = 0;
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_wbit = wb;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, {tag, " R2 ready low while busy"}, cmd_ready, 0);
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    got_done = done;
    got_rd = rd_bit;
    got_arb = err_arb;
    got_tmo = err_tmo;
    done_cyc = cyc;
    chk(got_done == 1'b1, {tag, " R2 done pulse"}, got_done, 1);
    @(negedge clk);
    chk(done == 1'b0 && cmd_ready == 1'b1, {tag, " R2 single done"}, done, 0);
  endtask

  task automatic cmp_seq(input string tag);
    chk(act_q.size() == exp_q.size(), {tag, " move count"}, act_q.size(), exp_q.size());
    for (int i = 0; i < act_q.size() && i < exp_q.size(); i++)
      chk(act_q[i] == exp_q[i], {tag, " move value"}, act_q[i], exp_q[i]);
  endtask

  task automatic chk_err(input string tag, input bit ea, input bit et);
    chk(got_arb == ea, {tag, " err_arb"}, got_arb, ea);
    chk(got_tmo == et, {tag, " err_tmo"}, got_tmo, et);
  endtask

  task automatic do_start_ok(input string tag);
    begin_cmd(); exp_set(0, 1); exp_set(1, 1);
    do_cmd(OP_START, 0, tag);
    cmp_seq(tag); chk_err(tag, 0, 0);
  endtask

  task automatic do_write_ok(input bit b, input string tag);
    begin_cmd(); exp_set(1, !b); exp_set(0, !b); exp_set(1, !b);
    do_cmd(OP_WRITE, b, tag);
    cmp_seq(tag); chk_err(tag, 0, 0);
  endtask

  task automatic do_stop_ok(input string tag);
    begin_cmd(); exp_set(exp_last[1], 1); exp_set(0, 1); exp_set(0, 0);
    do_cmd(OP_STOP, 0, tag);
    cmp_seq(tag); chk_err(tag, 0, 0);
  endtask

  initial begin
    int s0, p0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(scl_drive_low == 0 && sda_drive_low == 0, "R1 wires released", {scl_drive_low, sda_drive_low}, 0);
    chk(cmd_ready == 1, "R1 ready", cmd_ready, 1);
    chk(done == 0 && err_arb == 0 && err_tmo == 0, "R1 flags", {done, err_arb, err_tmo}, 0);

    // R3 START
    s0 = starts;
    do_start_ok("R3 start");
    chk(starts == s0 + 1, "R3 start condition on bus", starts - s0, 1);

    // R6 write 1 then 0
    do_write_ok(1, "R6 write one");
    do_write_ok(0, "R6 write zero");

    // R7 read with slave driving 0, then released
    slave_sda = 1'b1;
    begin_cmd(); exp_set(1, 0); exp_set(0, 0); exp_set(1, 0);
    do_cmd(OP_READ, 0, "R7 read zero");
    slave_sda = 1'b0;
    cmp_seq("R7 read zero"); chk_err("R7 read zero", 0, 0);
    chk(got_rd == 0, "R7 read zero value", got_rd, 0);
    begin_cmd(); exp_set(1, 0); exp_set(0, 0); exp_set(1, 0);
    do_cmd(OP_READ, 0, "R7 read one");
    cmp_seq("R7 read one"); chk_err("R7 read one", 0, 0);
    chk(got_rd == 1, "R7 read one value", got_rd, 1);

    // R4 repeated START
    s0 = starts;
    begin_cmd(); exp_set(1, 0); exp_set(0, 0); exp_set(0, 1); exp_set(1, 1);
    do_cmd(OP_RESTART, 0, "R4 restart");
    cmp_seq("R4 restart"); chk_err("R4 restart", 0, 0);
    chk(starts == s0 + 1, "R4 start condition on bus", starts - s0, 1);

    // R5 STOP
    p0 = stops;
    do_stop_ok("R5 stop");
    chk(stops == p0 + 1, "R5 stop condition on bus", stops - p0, 1);

    // R8 clock stretching during a write
    do_start_ok("R8 start");
    stretch = 1'b1;
    begin_cmd(); exp_set(1, 0); exp_set(0, 0); exp_set(1, 0);
    fork
      do_cmd(OP_WRITE, 1, "R8 stretched write");
      begin
        repeat (60) @(negedge clk);
        stretch = 1'b0;
        rel_cyc = cyc;
      end
    join
    cmp_seq("R8 stretched write"); chk_err("R8 stretched write", 0, 0);
    chk(done_cyc > rel_cyc, "R8 done after stretch ends", done_cyc, rel_cyc);

    // R10 arbitration lost on a written 1
    slave_sda = 1'b1;
    begin_cmd(); exp_set(1, 0); exp_set(0, 0);
    do_cmd(OP_WRITE, 1, "R10 arb write");
    cmp_seq("R10 arb write"); chk_err("R10 arb write", 1, 0);
    chk(scl_drive_low == 0 && sda_drive_low == 0, "R12 release after arb", {scl_drive_low, sda_drive_low}, 0);

    // R3 arbitration lost at START: data held low, no move
    begin_cmd();
    do_cmd(OP_START, 0, "R3 start arb");
    slave_sda = 1'b0;
    cmp_seq("R3 start arb"); chk_err("R3 start arb", 1, 0);

    // R9 timeout during a stretched write
    repeat (4) @(negedge clk);
    do_start_ok("R9 start");
    stretch = 1'b1;
    tmo_expired = 1'b1;
    begin_cmd(); exp_set(1, 1); exp_set(0, 1); exp_set(0, 0);
    do_cmd(OP_WRITE, 0, "R9 tmo write");
    stretch = 1'b0;
    tmo_expired = 1'b0;
    cmp_seq("R9 tmo write"); chk_err("R9 tmo write", 0, 1);

    // R12 timeout in STOP keeps the wires
    do_start_ok("R12 start");
    stretch = 1'b1;
    tmo_expired = 1'b1;
    begin_cmd(); exp_set(0, 1);
    do_cmd(OP_STOP, 0, "R12 stop tmo");
    cmp_seq("R12 stop tmo"); chk_err("R12 stop tmo", 0, 1);
    repeat (20) @(negedge clk);
    chk(scl_drive_low == 0 && sda_drive_low == 1, "R12 stop keeps wires", {scl_drive_low, sda_drive_low}, 1);
    stretch = 1'b0;
    tmo_expired = 1'b0;
    do_stop_ok("R12 stop retry");

    // R13 unused op codes
    for (int c = 5; c < 8; c++) begin
      begin_cmd();
      do_cmd(3'(c), 0, "R13 unused op");
      cmp_seq("R13 unused op"); chk_err("R13 unused op", 0, 0);
    end

    // R11 zero and longer half-bit delays
    half_cycles = 16'd0;
    do_start_ok("R11 zero start");
    do_write_ok(1, "R11 zero write");
    do_stop_ok("R11 zero stop");
    half_cycles = 16'd9;
    do_start_ok("R11 long start");
    do_write_ok(0, "R11 long write");
    do_stop_ok("R11 long stop");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule